// File: doc/BRIEF.md
# Indexed Interrupt Routing Table

This block holds the programmable routing table of a 24-input interrupt controller. Software reaches it through only two 32-bit locations on a small bus slave port. One is a selector that names an internal register. The other is a data window that reads or writes whatever register the selector currently names. Behind the window are an identification field, a constant version word, an arbitration word that mirrors the identification field, and one 64-bit routing entry per interrupt input. Each entry is reached as a low half and a high half.

Each entry has two status bits that belong to the hardware: delivery status (bit 12) and remote IRR (bit 14). Software writes to the low half never change them. A delivery engine alongside the block sets and clears these bits through a dedicated update port. The engine also reads every entry at once from a wide parallel output. Delivery of interrupts, message building and end-of-interrupt processing are handled outside this block.

Top module: `irq_route_regfile`

## Requirements
- R1: Only bus offset 0x00 (selector) and bus offset 0x10 (window) respond. At any other offset a write changes nothing and a read leaves `bus_rvalid` low.
- R2: The block accepts an access only when `bus_bytes` equals 4. Any other size is dropped: writes change nothing and reads leave `bus_rvalid` low.
- R3: An accepted read raises `bus_rvalid` with `bus_rdata` on the clock edge that samples the request. A read of offset 0x00 returns the full 32-bit value last written to the selector.
- R4: A window write with selector 0x00 keeps `bus_wdata[27:24]` as a 4-bit ID. A window read with selector 0x00 or 0x02 returns the ID in bits 27:24 and zeros in all other bits. A window write with selector 0x02 has no effect.
- R5: A window read with selector 0x01 returns {8'h00, 8'(N-1), 8'h00, 8'h11}, which is 0x00170011 for 24 entries. Window writes to selector 0x01, whether zero or any other value, change no state.
- R6: Selector 0x10+2n maps to bits 31:0 of entry n, and 0x11+2n maps to bits 63:32. A high-half write replaces all of bits 63:32. A window read at any other selector (0x03..0x0F, or 0x10+2N and above) returns 0 with `bus_rvalid` high, and a window write there has no effect.
- R7: A low-half write takes from `bus_wdata` only the bits set in 0xFFFF_AFFF. Bits 12 and 14 of the entry keep their previous values.
- R8: After reset every entry equals 0x0000_0000_0001_0000, which means the mask bit (16) is set and all other bits are zero. The selector and the ID are both 0.
- R9: When `upd_valid` is high, `upd_ds_we` writes `upd_ds_val` into bit 12 of entry `upd_idx`, and `upd_irr_we` writes `upd_irr_val` into bit 14, at the next edge. If a bus write hits the same entry in the same cycle, the engine's values win for those two bits and the rest of the bus write still takes effect.
- R10: `entries_o[64n+63:64n]` always shows entry n, and it reflects a write from the edge that performs that write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_bytes | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned |
| upd_valid | input | 1 | Status update from delivery engine |
| upd_idx | input | 5 | Entry index of the update |
| upd_ds_we | input | 1 | Update delivery status bit |
| upd_ds_val | input | 1 | New delivery status value |
| upd_irr_we | input | 1 | Update remote IRR bit |
| upd_irr_val | input | 1 | New remote IRR value |
| entries_o | output | 1536 | All entries, entry n at bits 64n+63:64n |

## Verification
Every state change, whether from a bus write or from an engine update, appears on `entries_o` right after the edge that samples the request. Read data and `bus_rvalid` are registered on that same edge. The bench drives each request on a falling edge and samples the results on the next falling edge, which is half a cycle after the single register stage. It then clears the request so that each result comes from exactly one edge. Checks on ignored accesses read the state back through the window or compare `entries_o` against the bench's model after the stimulus and before any later change.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
    localparam logic [7:0]  OFF_SEL   = 8'h00;
    localparam logic [7:0]  OFF_WIN   = 8'h10;
    localparam logic [7:0]  SEL_ID    = 8'h00;
    localparam logic [7:0]  SEL_VER   = 8'h01;
    localparam logic [7:0]  SEL_ARB   = 8'h02;
    localparam logic [7:0]  SEL_TBL   = 8'h10;
    localparam logic [7:0]  VER_CODE  = 8'h11;
    localparam int          BIT_DS    = 12;
    localparam int          BIT_IRR   = 14;
    localparam logic [31:0] LO_KEEP   = 32'h0000_5000;
    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_LO,
        TGT_HI
    } tgt_e;
endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int N      = 24,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        sel,
    output logic              hit_sel,
    output logic              hit_win,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [7:0] TBL_END = SEL_TBL + 8'(2 * N);

    logic [7:0] rel;

    assign hit_sel = (addr == ADDR_W'(OFF_SEL));
    assign hit_win = (addr == ADDR_W'(OFF_WIN));
    assign rel     = sel - SEL_TBL;

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (sel == SEL_ID) begin
            tgt = TGT_ID;
        end else if (sel == SEL_VER) begin
            tgt = TGT_VER;
        end else if (sel == SEL_ARB) begin
            tgt = TGT_ARB;
        end else if (sel >= SEL_TBL && sel < TBL_END) begin
            tgt = sel[0] ? TGT_HI : TGT_LO;
            idx = IDX_W'(rel >> 1);
        end
    end
endmodule

// File: rtl/irq_rf_table.sv
module irq_rf_table
    import irq_rf_pkg::*;
#(
    parameter int N     = 24,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_ds_we,
    input  logic             upd_ds_val,
    input  logic             upd_irr_we,
    input  logic             upd_irr_val,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_hi,
    output logic [31:0]      rd_data,
    output logic [N*64-1:0]  entries_o
);
    typedef struct packed {
        logic [N-1:0][63:0] ent;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_hi) begin
                st_d.ent[wr_idx][63:32] = wr_data;
            end else begin
                st_d.ent[wr_idx][31:0] = (st_q.ent[wr_idx][31:0] & LO_KEEP)
                                       | (wr_data & ~LO_KEEP);
            end
        end
        if (upd_valid) begin
            if (upd_ds_we)  st_d.ent[upd_idx][BIT_DS]  = upd_ds_val;
            if (upd_irr_we) st_d.ent[upd_idx][BIT_IRR] = upd_irr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.ent[i] <= ENTRY_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = rd_hi ? st_q.ent[rd_idx][63:32] : st_q.ent[rd_idx][31:0];

    for (genvar g = 0; g < N; g++) begin : g_out
        assign entries_o[g*64 +: 64] = st_q.ent[g];
    end

    // Checker state captured at each edge for the properties below
    logic             kept_q;
    logic [IDX_W-1:0] kept_idx_q;
    logic [1:0]       kept_st_q;
    logic             eng_q;
    logic [IDX_W-1:0] eng_idx_q;
    logic             eng_val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q     <= 1'b0;
            kept_idx_q <= '0;
            kept_st_q  <= '0;
            eng_q      <= 1'b0;
            eng_idx_q  <= '0;
            eng_val_q  <= 1'b0;
        end else begin
            kept_q     <= wr_en && !wr_hi && !(upd_valid && upd_idx == wr_idx);
            kept_idx_q <= wr_idx;
            kept_st_q  <= {st_q.ent[wr_idx][BIT_IRR], st_q.ent[wr_idx][BIT_DS]};
            eng_q      <= upd_valid && upd_ds_we;
            eng_idx_q  <= upd_idx;
            eng_val_q  <= upd_ds_val;
        end
    end

    // R7
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kept_q |-> {entries_o[64*kept_idx_q + BIT_IRR], entries_o[64*kept_idx_q + BIT_DS]} == kept_st_q);

    // R9
    engine_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q |-> entries_o[64*eng_idx_q + BIT_DS] == eng_val_q);
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_rf_pkg::*;
#(
    parameter int N = 24,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [7:0]       bus_addr,
    input  logic [2:0]       bus_bytes,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_ds_we,
    input  logic             upd_ds_val,
    input  logic             upd_irr_we,
    input  logic             upd_irr_val,
    output logic [N*64-1:0]  entries_o
);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(N - 1), 8'h00, VER_CODE};

    typedef struct packed {
        logic [31:0] sel;
        logic [3:0]  id;
        logic [31:0] rdata;
        logic        rvalid;
    } top_t;

    top_t st_d, st_q;

    logic             acc;
    logic             hit_sel, hit_win;
    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    logic [31:0]      tbl_rd;
    logic             tbl_we;

    assign acc = bus_valid && (bus_bytes == 3'd4);

    irq_rf_decode #(.N(N), .ADDR_W(8), .IDX_W(IDX_W)) u_dec (
        .addr    (bus_addr),
        .sel     (st_q.sel[7:0]),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .tgt     (tgt),
        .idx     (idx)
    );

    assign tbl_we = acc && hit_win && bus_write && (tgt == TGT_LO || tgt == TGT_HI);

    irq_rf_table #(.N(N), .IDX_W(IDX_W)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (tbl_we),
        .wr_hi       (tgt == TGT_HI),
        .wr_idx      (idx),
        .wr_data     (bus_wdata),
        .upd_valid   (upd_valid),
        .upd_idx     (upd_idx),
        .upd_ds_we   (upd_ds_we),
        .upd_ds_val  (upd_ds_val),
        .upd_irr_we  (upd_irr_we),
        .upd_irr_val (upd_irr_val),
        .rd_idx      (idx),
        .rd_hi       (tgt == TGT_HI),
        .rd_data     (tbl_rd),
        .entries_o   (entries_o)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        if (acc && hit_sel) begin
            if (bus_write) begin
                st_d.sel = bus_wdata;
            end else begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = st_q.sel;
            end
        end else if (acc && hit_win) begin
            if (bus_write) begin
                if (tgt == TGT_ID) st_d.id = bus_wdata[27:24];
            end else begin
                st_d.rvalid = 1'b1;
                unique case (tgt)
                    TGT_ID, TGT_ARB: st_d.rdata = {4'h0, st_q.id, 24'h0};
                    TGT_VER:         st_d.rdata = VER_WORD;
                    TGT_LO, TGT_HI:  st_d.rdata = tbl_rd;
                    default:         st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;

    // R2
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_bytes != 3'd4) |=> !bus_rvalid);

    // R3
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == OFF_SEL) |=> $stable(st_q.sel));

    // R4
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == OFF_WIN) |=> $stable(st_q.id));
endmodule

// File: tb/irq_route_regfile_tb.sv
`timescale 1ns/1ps
module irq_route_regfile_tb;
    localparam int N = 24;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_valid, bus_write;
    logic [7:0]      bus_addr;
    logic [2:0]      bus_bytes;
    logic [31:0]     bus_wdata, bus_rdata;
    logic            bus_rvalid;
    logic            upd_valid, upd_ds_we, upd_ds_val, upd_irr_we, upd_irr_val;
    logic [4:0]      upd_idx;
    logic [N*64-1:0] entries_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] model [N];
    logic [3:0]  id_exp;

    always #2.5 clk = ~clk;

    irq_route_regfile #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .upd_valid(upd_valid),
        .upd_idx(upd_idx), .upd_ds_we(upd_ds_we), .upd_ds_val(upd_ds_val),
        .upd_irr_we(upd_irr_we), .upd_irr_val(upd_irr_val), .entries_o(entries_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_bytes = sz;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_bytes = sz;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_valid = 0;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d, output logic v);
        bus_wr(8'h00, {24'h0, s}, 3'd4);
        bus_rd(8'h10, 3'd4, d, v);
    endtask

    task automatic cmp_all(input string req);
        bit ok = 1;
        for (int n = 0; n < N; n++) if (entries_o[n*64 +: 64] !== model[n]) ok = 0;
        chk(ok, req, 64'(ok), 64'd1);
    endtask

    function automatic logic [31:0] lo_merge(input logic [31:0] old, input logic [31:0] w);
        return (old & 32'h0000_5000) | (w & 32'hFFFF_AFFF);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        logic [31:0] lo, hi;
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_bytes = 0; bus_wdata = 0;
        upd_valid = 0; upd_idx = 0; upd_ds_we = 0; upd_ds_val = 0; upd_irr_we = 0; upd_irr_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int n = 0; n < N; n++) model[n] = 64'h0000_0000_0001_0000;
        id_exp = 0;

        // R8 reset state
        chk(bus_rvalid === 1'b0, "R8 rvalid", 64'(bus_rvalid), 0);
        for (int n = 0; n < N; n++)
            chk(entries_o[n*64 +: 64] === 64'h1_0000, "R8 R10 reset entry", entries_o[n*64 +: 64], 64'h1_0000);
        bus_rd(8'h00, 3'd4, d, v);
        chk(v && d == 0, "R8 R3 selector reset", {31'h0, v, d}, {31'h0, 1'b1, 32'h0});
        bus_wr(8'h10, 32'h0, 3'd4);
        bus_rd(8'h10, 3'd4, d, v);
        chk(v && d == 0, "R8 id reset", 64'(d), 0);

        // R5 version word, writes ignored
        win_rd(8'h01, d, v);
        chk(v && d == {8'h00, 8'(N-1), 8'h00, 8'h11}, "R5 version", 64'(d), 64'h0017_0011);
        bus_wr(8'h10, 32'h0, 3'd4);
        bus_wr(8'h10, 32'hFFFF_FFFF, 3'd4);
        bus_rd(8'h10, 3'd4, d, v);
        chk(v && d == 32'h0017_0011, "R5 version after writes", 64'(d), 64'h0017_0011);
        cmp_all("R5 entries untouched");

        // R4 id and arbitration
        bus_wr(8'h00, 32'h0, 3'd4);
        bus_wr(8'h10, 32'hF7FF_FFFF, 3'd4);
        id_exp = 4'h7;
        bus_rd(8'h10, 3'd4, d, v);
        chk(v && d == 32'h0700_0000, "R4 id read", 64'(d), 64'h0700_0000);
        win_rd(8'h02, d, v);
        chk(v && d == 32'h0700_0000, "R4 arb mirrors id", 64'(d), 64'h0700_0000);
        bus_wr(8'h10, 32'h0C00_0000, 3'd4);
        bus_rd(8'h10, 3'd4, d, v);
        chk(v && d == 32'h0700_0000, "R4 arb write ignored", 64'(d), 64'h0700_0000);

        // R6 R7 R10 sweep of all entries
        for (int n = 0; n < N; n++) begin
            lo = 32'h1234_5678 + 32'(n) * 32'h0001_1111 | 32'h0000_5000;
            hi = 32'hA500_0000 ^ (32'(n) * 32'h0101_0307);
            bus_wr(8'h00, 32'(8'h10 + 2*n), 3'd4);
            bus_wr(8'h10, lo, 3'd4);
            bus_wr(8'h00, 32'(8'h11 + 2*n), 3'd4);
            bus_wr(8'h10, hi, 3'd4);
            model[n] = {hi, lo_merge(model[n][31:0], lo)};
            chk(entries_o[n*64 +: 64] === model[n], "R6 R7 R10 entry write", entries_o[n*64 +: 64], model[n]);
            bus_rd(8'h10, 3'd4, d, v);
            chk(v && d == hi, "R6 high readback", 64'(d), 64'(hi));
            win_rd(8'(8'h10 + 2*n), d, v);
            chk(v && d == model[n][31:0], "R6 R7 low readback", 64'(d), 64'(model[n][31:0]));
        end

        // R9 engine sets status bits, R7 low writes keep them
        for (int n = 0; n < N; n++) begin
            @(negedge clk);
            upd_valid = 1; upd_idx = 5'(n);
            upd_ds_we = 1; upd_ds_val = n[0];
            upd_irr_we = 1; upd_irr_val = n[1];
            @(negedge clk);
            upd_valid = 0; upd_ds_we = 0; upd_irr_we = 0;
            model[n][12] = n[0];
            model[n][14] = n[1];
        end
        cmp_all("R9 engine status update");
        for (int n = 0; n < N; n++) begin
            bus_wr(8'h00, 32'(8'h10 + 2*n), 3'd4);
            bus_wr(8'h10, (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h0, 3'd4);
            model[n][31:0] = lo_merge(model[n][31:0], (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h0);
        end
        cmp_all("R7 status bits kept");

        // R9 collision on entry 5: engine wins bits 12/14, rest of bus write lands
        bus_wr(8'h00, 32'h1A, 3'd4);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h10; bus_bytes = 3'd4; bus_wdata = 32'h0000_00C3;
        upd_valid = 1; upd_idx = 5'd5; upd_ds_we = 1; upd_ds_val = 1; upd_irr_we = 1; upd_irr_val = 1;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; upd_valid = 0; upd_ds_we = 0; upd_irr_we = 0;
        model[5][31:0] = 32'h0000_50C3;
        chk(entries_o[5*64 +: 64] === model[5], "R9 collision set", entries_o[5*64 +: 64], model[5]);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h10; bus_bytes = 3'd4; bus_wdata = 32'hFFFF_FFFF;
        upd_valid = 1; upd_idx = 5'd5; upd_ds_we = 1; upd_ds_val = 0; upd_irr_we = 1; upd_irr_val = 0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; upd_valid = 0; upd_ds_we = 0; upd_irr_we = 0;
        model[5][31:0] = 32'hFFFF_AFFF;
        chk(entries_o[5*64 +: 64] === model[5], "R9 collision clear", entries_o[5*64 +: 64], model[5]);

        // R6 undefined selectors read 0 and ignore writes
        for (int s = 3; s < 256; s++) begin
            if (s >= 8'h10 && s < 8'h10 + 2*N) continue;
            bus_wr(8'h00, 32'(s), 3'd4);
            bus_wr(8'h10, 32'hFFFF_FFFF, 3'd4);
            bus_rd(8'h10, 3'd4, d, v);
            chk(v && d == 0, "R6 undefined selector", {31'h0, v, d}, {31'h0, 1'b1, 32'h0});
        end
        cmp_all("R6 undefined writes ignored");
        win_rd(8'h00, d, v);
        chk(d == {4'h0, id_exp, 24'h0}, "R6 id untouched", 64'(d), 64'({4'h0, id_exp, 24'h0}));

        // R1 other bus offsets
        bus_wr(8'h00, 32'h0000_0010, 3'd4);
        for (int a = 1; a < 256; a++) begin
            if (a == 8'h10) continue;
            bus_wr(8'(a), 32'hDEAD_BEEF, 3'd4);
            bus_rd(8'(a), 3'd4, d, v);
            chk(v === 1'b0, "R1 other offset no data", 64'(v), 0);
        end
        bus_rd(8'h00, 3'd4, d, v);
        chk(v && d == 32'h10, "R1 R3 selector kept", 64'(d), 64'h10);
        cmp_all("R1 entries kept");

        // R2 access sizes other than 4
        for (int sz = 0; sz < 8; sz++) begin
            if (sz == 4) continue;
            bus_wr(8'h00, 32'h0000_0033, 3'(sz));
            bus_wr(8'h10, 32'h0, 3'(sz));
            bus_rd(8'h00, 3'(sz), d, v);
            chk(v === 1'b0, "R2 bad size read", 64'(v), 0);
            bus_rd(8'h10, 3'(sz), d, v);
            chk(v === 1'b0, "R2 bad size window read", 64'(v), 0);
        end
        bus_rd(8'h00, 3'd4, d, v);
        chk(v && d == 32'h10, "R2 selector unchanged", 64'(d), 64'h10);
        cmp_all("R2 entries unchanged");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule